// File: doc/BRIEF.md
# Shared-Inversion Compact ALU

A purely combinational arithmetic and logic unit. It takes two operands, `r_in` and `s_in`, each `WIDTH` bits wide, and a 3-bit function code. It returns a `WIDTH`-bit result and a carry-out. All function units compute continuously from the operands: one adder, an AND path and an XOR path. Only the output selection decides which of them drives the result.

The adder, the AND path and the XOR path are each shared by a pair of functions. Function bit 0 XOR-inverts `r_in` and function bit 1 XOR-inverts `s_in` before the single adder. The adder carry-in is the OR of those two bits. This gives add, S minus R and R minus S from one carry chain. Function bit 0 also turns AND into AND with inverted R, and XOR into XNOR. The result is picked by a two-level tree of three 2:1 multiplexers that is steered by function bits 2 and 1.

Top module: `shinv_alu`

## Requirements
- R1: With `func` = 3'b000 the result is `r_in + s_in` modulo 2^WIDTH, and `carry_out` is the carry out of the MSB. For example, 0001 + 0010 gives 0011 with carry 0.
- R2: With `func` = 3'b001 the result is `s_in - r_in` modulo 2^WIDTH, and `carry_out` is 1 exactly when `s_in >= r_in`.
- R3: With `func` = 3'b010 the result is `r_in - s_in` modulo 2^WIDTH, and `carry_out` is 1 exactly when `r_in >= s_in`.
- R4: With `func` = 3'b011 (both operands inverted, a combination with no named use) the output is defined as `~r_in + ~s_in + 1`. The result is the low WIDTH bits of that sum, and `carry_out` is bit WIDTH of that sum.
- R5: With `func` = 3'b100 the result is `r_in & s_in`. With `func` = 3'b101 the result is `~r_in & s_in`.
- R6: With `func` = 3'b110 the result is `r_in ^ s_in`. With `func` = 3'b111 the result is `~(r_in ^ s_in)`.
- R7: `carry_out` is 0 for every code with `func[2]` = 1.
- R8: Changing only `func` while the operands stay fixed switches the result between function units with no other input. With operands 0001 and 0010, code 000 gives 0011 and code 100 gives 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| r_in | input | WIDTH | Operand R |
| s_in | input | WIDTH | Operand S |
| func | input | 3 | Function code: bit 2 selects logic (1) or arithmetic (0); bits 1 and 0 select the variant |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Adder carry from the MSB; 0 for logic codes |

## Verification
The bench builds the block with the default WIDTH of 4. At that width every pair of operands times every function code comes to 2048 vectors, so all of them can be applied. This covers every carry boundary exhaustively: equal operands in both subtract directions, all-ones wraparound in add, and the undefined both-inverted code. It also covers all bit patterns of the AND-NOT and XNOR paths.

// File: rtl/shinv_alu.sv
module shinv_alu #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] r_in,
  input  logic [WIDTH-1:0] s_in,
  input  logic [2:0]       func,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] r_mask, s_mask, r_x, s_x;
  logic [WIDTH:0]   sum_ext;
  logic [WIDTH-1:0] and_out, xor_out;
  logic [WIDTH-1:0] mux_lo, mux_hi, sel;
  logic             cin, co;

  always_comb begin
    r_mask  = {WIDTH{func[0]}};
    s_mask  = {WIDTH{func[1]}};
    r_x     = r_in ^ r_mask;
    s_x     = s_in ^ s_mask;
    cin     = func[0] | func[1];
    sum_ext = {1'b0, r_x} + {1'b0, s_x} + {{WIDTH{1'b0}}, cin};
    and_out = r_x & s_in;
    xor_out = r_in ^ s_in ^ r_mask;

    mux_lo  = func[1] ? sum_ext[WIDTH-1:0] : sum_ext[WIDTH-1:0];
    mux_hi  = func[1] ? xor_out : and_out;
    sel     = func[2] ? mux_hi : mux_lo;
    co      = func[2] ? 1'b0 : sum_ext[WIDTH];

    result    = sel;
    carry_out = co;

    if (func == 3'b001) AST_SSUB_INVERSE: assert ((sel + r_in) == s_in);            // R2
    if (func == 3'b010) AST_RSUB_INVERSE: assert ((sel + s_in) == r_in);            // R3
    if (func == 3'b010) AST_RSUB_BORROW: assert (co == (r_in >= s_in));             // R3
    if (func == 3'b000) AST_ADD_CARRY: assert (co == (sel < r_in));                 // R1
    if (func[2:1] == 2'b10) AST_AND_WITHIN_S: assert ((sel & ~s_in) == ZERO);       // R5
    if (func == 3'b110) AST_XOR_RECOVER: assert ((sel ^ r_in) == s_in);             // R6
    if (func == 3'b111) AST_XNOR_RECOVER: assert ((sel ^ r_in) == ~s_in);           // R6
    if (func[2]) AST_LOGIC_NO_CARRY: assert (!co);                                  // R7
  end
endmodule

// File: tb/shinv_alu_tb_top.sv
module shinv_alu_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] r_in, s_in, result;
  logic [2:0]   func;
  logic         carry_out;

  shinv_alu #(.WIDTH(W)) dut_i (
    .r_in(r_in), .s_in(s_in), .func(func),
    .result(result), .carry_out(carry_out)
  );

  typedef struct packed {
    logic [W-1:0] res;
    logic         co;
    logic [2:0]   f;
    logic [W-1:0] r;
    logic [W-1:0] s;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  function automatic exp_t model(logic [2:0] f, logic [W-1:0] r, logic [W-1:0] s);
    exp_t e;
    logic [W:0] t;
    e.f = f; e.r = r; e.s = s;
    case (f)
      3'b000: begin t = {1'b0, r} + {1'b0, s}; e.res = t[W-1:0]; e.co = t[W]; end
      3'b001: begin e.res = s - r; e.co = (s >= r); end
      3'b010: begin e.res = r - s; e.co = (r >= s); end
      3'b011: begin t = {1'b0, ~r} + {1'b0, ~s} + 1; e.res = t[W-1:0]; e.co = t[W]; end
      3'b100: begin e.res = r & s; e.co = 1'b0; end
      3'b101: begin e.res = ~r & s; e.co = 1'b0; end
      3'b110: begin e.res = r ^ s; e.co = 1'b0; end
      default: begin e.res = ~(r ^ s); e.co = 1'b0; end
    endcase
    return e;
  endfunction

  function automatic string tag(logic [2:0] f);
    case (f)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100, 3'b101: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(logic [2:0] f, logic [W-1:0] r, logic [W-1:0] s);
    @(posedge clk);
    #1;
    r_in = r; s_in = s; func = f;
    q.push_back(model(f, r, s));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (result !== e.res) begin
        mismatched++;
        $display("FAIL %s result f=%b r=%h s=%h actual=%h expected=%h", tag(e.f), e.f, e.r, e.s, result, e.res);
      end
      compared++;
      if (carry_out !== e.co) begin
        mismatched++;
        $display("FAIL %s carry (R7 when logic) f=%b r=%h s=%h actual=%b expected=%b",
                 tag(e.f), e.f, e.r, e.s, carry_out, e.co);
      end
    end
  end

  initial begin
    r_in = '0; s_in = '0; func = '0;
    // R8: worked example, only func changes between add and AND
    drive(3'b000, 4'b0001, 4'b0010);
    drive(3'b100, 4'b0001, 4'b0010);
    drive(3'b000, 4'b0001, 4'b0010);
    // exhaustive sweep covering R1..R7
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < (1 << W); r++)
        for (int s = 0; s < (1 << W); s++)
          drive(3'(f), W'(r), W'(s));
    @(posedge clk);
    @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule